// File: doc/BRIEF.md
# Clock Output Stop Controller

This block sits between the clock generators of a system clock chip and its output pins. It receives already generated clocks for several output groups: CPU, PCI, a free-running PCI copy, AGP, IOAPIC, reference, fixed 48 MHz and selectable 24/48 MHz. For each output it decides whether the clock passes, is held low, or leaves its pin floating. Three active-low control inputs drive that decision. The CPU stop input halts the CPU group. The PCI stop input halts the PCI group. The power-down input halts every output. Per-output enable bits and one global float bit come from a configuration register outside the block.

Every run decision is brought into the domain of the clock it governs. A chain of flops clocked on the falling edge of that clock does this, so the gate only opens or closes while the clock is low. An output therefore shows either a complete high phase or none at all. The last CPU output has a select bit that decides whether the CPU stop input affects it. AGP, IOAPIC, reference and the fixed-frequency outputs ignore both stop inputs.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `pci_stop_n` is 0, every bit of `pci_clk_o` stays at 0 through its high phases. While it is 1, each enabled bit of `pci_clk_o` copies `pci_clk_i`.
- R2: `pci_free_o` keeps running while `pci_stop_n` is 0, provided `pci_free_en` is 1 and power is up.
- R3: While `cpu_stop_n` is 0, every bit of `cpu_clk_o` except the highest-numbered one stays at 0.
- R4: The highest-numbered bit of `cpu_clk_o` stops with `cpu_stop_n` when `cpu_last_stoppable` is 1. It keeps running when that bit is 0.
- R5: `agp_clk_o`, `apic_clk_o`, `ref_clk_o`, `f48_o` and `f24_48_o` are unaffected by `cpu_stop_n` and `pci_stop_n`.
- R6: An output whose enable bit is 0 stays at 0. An output whose enable bit is 1 copies its source clock, unless a stop or power-down applies.
- R7: While `pwrdn_n` is 0, every clock output stays at 0. When `pwrdn_n` returns to 1, the enabled outputs start again.
- R8: `clk_oe_o` is 0 while `float_all` is 1, which releases all output pins. It is 1 while `float_all` is 0.
- R9: A change to any run condition made while a source clock is low leaves the next SYNC_STAGES high phases of that output unchanged. It takes effect on the high phase after that.
- R10: No clock output is ever high while its source clock is low. A started high phase is never cut short.
- R11: While `rst_n` is 0, all clock outputs are 0. After `rst_n` rises, enabled outputs start under the R9 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the synchroniser flops |
| cpu_clk_i | input | 1 | Source clock for the CPU group |
| pci_clk_i | input | 1 | Source clock for the PCI group and the free-running PCI output |
| agp_clk_i | input | 1 | Source clock for the AGP group |
| apic_clk_i | input | 1 | Source clock for the IOAPIC group |
| ref_clk_i | input | 1 | Source reference clock |
| f48_clk_i | input | 1 | Source fixed 48 MHz clock |
| f24_48_clk_i | input | 1 | Source selectable 24/48 MHz clock |
| cpu_stop_n | input | 1 | Active-low stop request for the CPU group |
| pci_stop_n | input | 1 | Active-low stop request for the PCI group |
| pwrdn_n | input | 1 | Active-low power-down, asynchronous to all clocks |
| cpu_en | input | N_CPU | Per-output enables, CPU group |
| cpu_last_stoppable | input | 1 | 1: highest CPU output obeys the CPU stop input |
| pci_en | input | N_PCI | Per-output enables, PCI group |
| pci_free_en | input | 1 | Enable for the free-running PCI output |
| agp_en | input | N_AGP | Per-output enables, AGP group |
| apic_en | input | N_APIC | Per-output enables, IOAPIC group |
| ref_en | input | N_REF | Per-output enables, reference group |
| f48_en | input | 1 | Enable for the fixed 48 MHz output |
| f24_48_en | input | 1 | Enable for the 24/48 MHz output |
| float_all | input | 1 | 1: release every output pin |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| pci_free_o | output | 1 | Gated free-running PCI clock |
| agp_clk_o | output | N_AGP | Gated AGP clocks |
| apic_clk_o | output | N_APIC | Gated IOAPIC clocks |
| ref_clk_o | output | N_REF | Gated reference clocks |
| f48_o | output | 1 | Gated fixed 48 MHz clock |
| f24_48_o | output | 1 | Gated 24/48 MHz clock |
| clk_oe_o | output | 1 | Pad drive enable shared by all clock outputs |

## Verification
The bench builds the block with three CPU outputs, four PCI outputs, three AGP, three IOAPIC and two reference outputs, and two synchroniser stages. It connects every source clock to one bench clock. Four PCI outputs are few enough that each enable bit can be given a distinct value within one pattern. Three CPU outputs keep a stoppable lower output next to the selectable top one. With a single clock, the two high phases before a change and the first high phase after it can be checked exactly for every output at once.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

   // Which stop request a gating group obeys
   typedef enum logic [1:0] {
      STOP_NONE = 2'd0,
      STOP_CPU  = 2'd1,
      STOP_PCI  = 2'd2
   } stop_src_e;

   // A lane runs when enabled, powered and not hit by an applicable stop
   function automatic logic lane_runs(input logic en,
                                      input logic powered,
                                      input logic stoppable,
                                      input logic stop_active);
      return en & powered & ~(stoppable & stop_active);
   endfunction

endpackage

// File: rtl/clk_gate_cell.sv
module clk_gate_cell #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n,
   input  logic run_i,
   output logic gclk_o
);

   logic [SYNC_STAGES-1:0] sync_q;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(negedge clk_i or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= run_i;
         end
      end else begin : g_chain
         always_ff @(negedge clk_i or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], run_i};
         end
      end
   endgenerate

   // The gate term changes only on a falling edge, so the AND never slices a high phase
   assign gclk_o = clk_i & sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/clk_gate_group.sv
module clk_gate_group
   import clk_stop_pkg::*;
#(
   parameter int        LANES       = 1,
   parameter int        SYNC_STAGES = 2,
   parameter stop_src_e STOP_SRC    = STOP_NONE
) (
   input  logic             clk_i,
   input  logic             rst_n,
   input  logic [LANES-1:0] en_i,
   input  logic [LANES-1:0] stoppable_i,
   input  logic             cpu_stop_n,
   input  logic             pci_stop_n,
   input  logic             pwrdn_n,
   output logic [LANES-1:0] gclk_o
);

   logic stop_active;

   generate
      if (STOP_SRC == STOP_CPU) begin : g_cpu_src
         assign stop_active = ~cpu_stop_n;
      end else if (STOP_SRC == STOP_PCI) begin : g_pci_src
         assign stop_active = ~pci_stop_n;
      end else begin : g_no_src
         logic unused_stops;
         assign unused_stops = cpu_stop_n ^ pci_stop_n ^ (^stoppable_i);
         assign stop_active  = 1'b0;
      end
   endgenerate

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic run;
      assign run = lane_runs(en_i[i], pwrdn_n, stoppable_i[i], stop_active);

      clk_gate_cell #(
         .SYNC_STAGES(SYNC_STAGES)
      ) u_cell (
         .clk_i (clk_i),
         .rst_n (rst_n),
         .run_i (run),
         .gclk_o(gclk_o[i])
      );
   end

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
   import clk_stop_pkg::*;
#(
   parameter int N_CPU       = 3,
   parameter int N_PCI       = 8,
   parameter int N_AGP       = 3,
   parameter int N_APIC      = 3,
   parameter int N_REF       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rst_n,
   input  logic              cpu_clk_i,
   input  logic              pci_clk_i,
   input  logic              agp_clk_i,
   input  logic              apic_clk_i,
   input  logic              ref_clk_i,
   input  logic              f48_clk_i,
   input  logic              f24_48_clk_i,
   input  logic              cpu_stop_n,
   input  logic              pci_stop_n,
   input  logic              pwrdn_n,
   input  logic [N_CPU-1:0]  cpu_en,
   input  logic              cpu_last_stoppable,
   input  logic [N_PCI-1:0]  pci_en,
   input  logic              pci_free_en,
   input  logic [N_AGP-1:0]  agp_en,
   input  logic [N_APIC-1:0] apic_en,
   input  logic [N_REF-1:0]  ref_en,
   input  logic              f48_en,
   input  logic              f24_48_en,
   input  logic              float_all,
   output logic [N_CPU-1:0]  cpu_clk_o,
   output logic [N_PCI-1:0]  pci_clk_o,
   output logic              pci_free_o,
   output logic [N_AGP-1:0]  agp_clk_o,
   output logic [N_APIC-1:0] apic_clk_o,
   output logic [N_REF-1:0]  ref_clk_o,
   output logic              f48_o,
   output logic              f24_48_o,
   output logic              clk_oe_o
);

   localparam int CPU_TOP = N_CPU - 1;

   // Elaboration-time parameter checks
   if (N_CPU < 1)       begin : g_bad_cpu  $error("N_CPU must be at least 1");       end
   if (N_PCI < 1)       begin : g_bad_pci  $error("N_PCI must be at least 1");       end
   if (N_AGP < 1)       begin : g_bad_agp  $error("N_AGP must be at least 1");       end
   if (N_APIC < 1)      begin : g_bad_apic $error("N_APIC must be at least 1");      end
   if (N_REF < 1)       begin : g_bad_ref  $error("N_REF must be at least 1");       end
   if (SYNC_STAGES < 1) begin : g_bad_sync $error("SYNC_STAGES must be at least 1"); end

   // Only the top CPU lane has a selectable response to the CPU stop
   logic [N_CPU-1:0] cpu_stoppable;
   always_comb begin
      cpu_stoppable          = '1;
      cpu_stoppable[CPU_TOP] = cpu_last_stoppable;
   end

   clk_gate_group #(
      .LANES(N_CPU), .SYNC_STAGES(SYNC_STAGES), .STOP_SRC(STOP_CPU)
   ) u_cpu (
      .clk_i(cpu_clk_i), .rst_n(rst_n), .en_i(cpu_en), .stoppable_i(cpu_stoppable),
      .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
      .gclk_o(cpu_clk_o)
   );

   clk_gate_group #(
      .LANES(N_PCI), .SYNC_STAGES(SYNC_STAGES), .STOP_SRC(STOP_PCI)
   ) u_pci (
      .clk_i(pci_clk_i), .rst_n(rst_n), .en_i(pci_en), .stoppable_i({N_PCI{1'b1}}),
      .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
      .gclk_o(pci_clk_o)
   );

   clk_gate_group #(
      .LANES(1), .SYNC_STAGES(SYNC_STAGES), .STOP_SRC(STOP_NONE)
   ) u_pci_free (
      .clk_i(pci_clk_i), .rst_n(rst_n), .en_i(pci_free_en), .stoppable_i(1'b0),
      .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
      .gclk_o(pci_free_o)
   );

   clk_gate_group #(
      .LANES(N_AGP), .SYNC_STAGES(SYNC_STAGES), .STOP_SRC(STOP_NONE)
   ) u_agp (
      .clk_i(agp_clk_i), .rst_n(rst_n), .en_i(agp_en), .stoppable_i({N_AGP{1'b0}}),
      .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
      .gclk_o(agp_clk_o)
   );

   clk_gate_group #(
      .LANES(N_APIC), .SYNC_STAGES(SYNC_STAGES), .STOP_SRC(STOP_NONE)
   ) u_apic (
      .clk_i(apic_clk_i), .rst_n(rst_n), .en_i(apic_en), .stoppable_i({N_APIC{1'b0}}),
      .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
      .gclk_o(apic_clk_o)
   );

   clk_gate_group #(
      .LANES(N_REF), .SYNC_STAGES(SYNC_STAGES), .STOP_SRC(STOP_NONE)
   ) u_ref (
      .clk_i(ref_clk_i), .rst_n(rst_n), .en_i(ref_en), .stoppable_i({N_REF{1'b0}}),
      .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
      .gclk_o(ref_clk_o)
   );

   clk_gate_group #(
      .LANES(1), .SYNC_STAGES(SYNC_STAGES), .STOP_SRC(STOP_NONE)
   ) u_f48 (
      .clk_i(f48_clk_i), .rst_n(rst_n), .en_i(f48_en), .stoppable_i(1'b0),
      .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
      .gclk_o(f48_o)
   );

   clk_gate_group #(
      .LANES(1), .SYNC_STAGES(SYNC_STAGES), .STOP_SRC(STOP_NONE)
   ) u_f24_48 (
      .clk_i(f24_48_clk_i), .rst_n(rst_n), .en_i(f24_48_en), .stoppable_i(1'b0),
      .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
      .gclk_o(f24_48_o)
   );

   // Pad drive enable shared by every clock output
   assign clk_oe_o = ~float_all;

endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
   parameter int N_CPU       = 3,
   parameter int N_PCI       = 8,
   parameter int N_AGP       = 3,
   parameter int SYNC_STAGES = 2
) (
   input logic             rst_n,
   input logic             cpu_clk_i,
   input logic             pci_clk_i,
   input logic             agp_clk_i,
   input logic             pwrdn_n,
   input logic [N_AGP-1:0] agp_en,
   input logic [N_CPU-1:0] cpu_clk_o,
   input logic [N_PCI-1:0] pci_clk_o,
   input logic [N_AGP-1:0] agp_clk_o
);

   localparam int CW = $clog2(SYNC_STAGES + 2) + 1;
   localparam int CMAX = SYNC_STAGES + 1;

   // Consecutive falling-edge samples with power-down held, per domain
   logic [CW-1:0] cpu_pd_cnt, pci_pd_cnt, agp_hold_cnt;
   logic [N_AGP-1:0] agp_en_q;

   always_ff @(negedge cpu_clk_i or negedge rst_n) begin
      if (!rst_n)                     cpu_pd_cnt <= '0;
      else if (pwrdn_n)               cpu_pd_cnt <= '0;
      else if (cpu_pd_cnt < CW'(CMAX)) cpu_pd_cnt <= cpu_pd_cnt + 1'b1;
   end

   always_ff @(negedge pci_clk_i or negedge rst_n) begin
      if (!rst_n)                     pci_pd_cnt <= '0;
      else if (pwrdn_n)               pci_pd_cnt <= '0;
      else if (pci_pd_cnt < CW'(CMAX)) pci_pd_cnt <= pci_pd_cnt + 1'b1;
   end

   // Consecutive samples with power up and an unchanged AGP enable vector
   always_ff @(negedge agp_clk_i or negedge rst_n) begin
      if (!rst_n) begin
         agp_hold_cnt <= '0;
         agp_en_q     <= '0;
      end else begin
         agp_en_q <= agp_en;
         if (!pwrdn_n)                      agp_hold_cnt <= '0;
         else if (agp_en != agp_en_q)       agp_hold_cnt <= CW'(1);
         else if (agp_hold_cnt < CW'(CMAX)) agp_hold_cnt <= agp_hold_cnt + 1'b1;
      end
   end

   // R10
   cpu_low_phase_quiet_chk: assert property (@(posedge cpu_clk_i) disable iff (!rst_n)
      cpu_clk_o == '0);

   // R10
   pci_low_phase_quiet_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_n)
      pci_clk_o == '0);

   // R7
   cpu_pwrdn_hold_chk: assert property (@(negedge cpu_clk_i) disable iff (!rst_n)
      (!pwrdn_n && cpu_pd_cnt >= CW'(SYNC_STAGES)) |-> cpu_clk_o == '0);

   // R7
   pci_pwrdn_hold_chk: assert property (@(negedge pci_clk_i) disable iff (!rst_n)
      (!pwrdn_n && pci_pd_cnt >= CW'(SYNC_STAGES)) |-> pci_clk_o == '0);

   // R5
   agp_follows_enable_chk: assert property (@(negedge agp_clk_i) disable iff (!rst_n)
      (pwrdn_n && agp_en == agp_en_q && agp_hold_cnt >= CW'(SYNC_STAGES))
      |-> agp_clk_o == agp_en);

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(
   .N_CPU(N_CPU), .N_PCI(N_PCI), .N_AGP(N_AGP), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .rst_n    (rst_n),
   .cpu_clk_i(cpu_clk_i),
   .pci_clk_i(pci_clk_i),
   .agp_clk_i(agp_clk_i),
   .pwrdn_n  (pwrdn_n),
   .agp_en   (agp_en),
   .cpu_clk_o(cpu_clk_o),
   .pci_clk_o(pci_clk_o),
   .agp_clk_o(agp_clk_o)
);

// File: tb/clk_stop_ctrl_bench.sv
module clk_stop_ctrl_bench;

   localparam int N_CPU = 3, N_PCI = 4, N_AGP = 3, N_APIC = 3, N_REF = 2, SYNC = 2;
   localparam int W = N_CPU + N_PCI + 1 + N_AGP + N_APIC + N_REF + 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwrdn_n = 1'b1;
   logic [N_CPU-1:0]  cpu_en = '1;
   logic              cpu_last_stoppable = 1'b1;
   logic [N_PCI-1:0]  pci_en = '1;
   logic              pci_free_en = 1'b1;
   logic [N_AGP-1:0]  agp_en = '1;
   logic [N_APIC-1:0] apic_en = '1;
   logic [N_REF-1:0]  ref_en = '1;
   logic              f48_en = 1'b1, f24_48_en = 1'b1, float_all = 1'b0;

   logic [N_CPU-1:0]  cpu_clk_o;
   logic [N_PCI-1:0]  pci_clk_o;
   logic              pci_free_o;
   logic [N_AGP-1:0]  agp_clk_o;
   logic [N_APIC-1:0] apic_clk_o;
   logic [N_REF-1:0]  ref_clk_o;
   logic              f48_o, f24_48_o, clk_oe_o;

   clk_stop_ctrl #(
      .N_CPU(N_CPU), .N_PCI(N_PCI), .N_AGP(N_AGP), .N_APIC(N_APIC),
      .N_REF(N_REF), .SYNC_STAGES(SYNC)
   ) u_clk_stop_ctrl (
      .rst_n(rst_n), .cpu_clk_i(clk), .pci_clk_i(clk), .agp_clk_i(clk),
      .apic_clk_i(clk), .ref_clk_i(clk), .f48_clk_i(clk), .f24_48_clk_i(clk),
      .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
      .cpu_en(cpu_en), .cpu_last_stoppable(cpu_last_stoppable), .pci_en(pci_en),
      .pci_free_en(pci_free_en), .agp_en(agp_en), .apic_en(apic_en), .ref_en(ref_en),
      .f48_en(f48_en), .f24_48_en(f24_48_en), .float_all(float_all),
      .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o),
      .agp_clk_o(agp_clk_o), .apic_clk_o(apic_clk_o), .ref_clk_o(ref_clk_o),
      .f48_o(f48_o), .f24_48_o(f24_48_o), .clk_oe_o(clk_oe_o)
   );

   typedef struct {
      logic [W-1:0] vec;
      logic         oe;
      string        req;
   } item_t;

   item_t        sb_q[$];
   int           checks = 0;
   int           fails  = 0;
   logic         in_reset = 1'b1;
   logic [W-1:0] last_exp = '0;

   function automatic logic [W-1:0] observed();
      return {cpu_clk_o, pci_clk_o, pci_free_o, agp_clk_o, apic_clk_o,
              ref_clk_o, f48_o, f24_48_o};
   endfunction

   // Expected high-phase levels straight from the requirements
   function automatic logic [W-1:0] model();
      logic [N_CPU-1:0] c;
      logic [N_PCI-1:0] p;
      for (int i = 0; i < N_CPU; i++)
         c[i] = cpu_en[i] & (cpu_stop_n | ((i == N_CPU - 1) & ~cpu_last_stoppable));
      for (int i = 0; i < N_PCI; i++)
         p[i] = pci_en[i] & pci_stop_n;
      if (in_reset || !pwrdn_n) return '0;
      return {c, p, pci_free_en, agp_en, apic_en, ref_en, f48_en, f24_48_en};
   endfunction

   // Driver: called just after a falling edge, after inputs changed
   task automatic apply(input string req);
      logic [W-1:0] nxt;
      item_t it;
      nxt = model();
      for (int k = 0; k < SYNC; k++) begin
         it.vec = last_exp; it.oe = ~float_all; it.req = {"R9 ", req};
         sb_q.push_back(it);
      end
      it.vec = nxt; it.oe = ~float_all; it.req = req;
      sb_q.push_back(it);
      last_exp = nxt;
      repeat (SYNC + 1) @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   // Monitor: high phase compared against the scoreboard, low phase must be quiet
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (observed() !== it.vec || clk_oe_o !== it.oe) begin
               fails++;
               $display("FAIL %s: outputs %b oe %b, expected %b oe %b",
                        it.req, observed(), clk_oe_o, it.vec, it.oe);
            end
            @(negedge clk);
            #2;
            checks++;
            if (observed() !== '0) begin
               fails++;
               $display("FAIL R10: low-phase outputs %b, expected %b", observed(), {W{1'b0}});
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk); #1;
      apply("R11");                 // held in reset: all low
      rst_n = 1'b1; in_reset = 1'b0;
      apply("R11");                 // start after release

      pci_stop_n = 1'b0;  apply("R1 R2");
      pci_stop_n = 1'b1;  apply("R1");

      cpu_stop_n = 1'b0;  apply("R3 R4");
      cpu_last_stoppable = 1'b0; apply("R4");
      pci_stop_n = 1'b0;  apply("R5");
      cpu_stop_n = 1'b1; pci_stop_n = 1'b1; cpu_last_stoppable = 1'b1; apply("R5");

      cpu_en = 3'b010; pci_en = 4'b1001; agp_en = 3'b101; apic_en = 3'b011;
      ref_en = 2'b10; f48_en = 1'b0; pci_free_en = 1'b0; apply("R6");
      cpu_en = 3'b101; pci_en = 4'b0110; agp_en = 3'b010; apic_en = 3'b100;
      ref_en = 2'b01; f48_en = 1'b1; f24_48_en = 1'b0; pci_free_en = 1'b1; apply("R6");
      cpu_en = '1; pci_en = '1; agp_en = '1; apic_en = '1; ref_en = '1;
      f24_48_en = 1'b1; apply("R6");

      pwrdn_n = 1'b0; apply("R7");
      pwrdn_n = 1'b1; apply("R7");

      float_all = 1'b1; apply("R8");
      float_all = 1'b0; apply("R8");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule